// File: doc/BRIEF.md
# Regulator Register File with Two-Wire Target Port

This block is the control-side front end of a programmable regulator. It listens on a two-wire serial bus (clock and data, open-drain, with the data pull-down given as a separate drive enable), recognises its own 7-bit device address, and gives the bus master write and read access to a small register file. The control fields and the two output-voltage codes are presented as plain outputs to the rest of the regulator logic. Two status inputs are folded into a read-only status byte: an overtemperature indication and a power-not-good indication.

Both bus lines pass through a two-flop synchroniser in the system clock domain. START, repeated START and STOP are detected from the synchronised lines. A write carries a register pointer followed by data bytes. A read sets the pointer with a write phase, then uses a repeated START and the read address to stream bytes back. The pointer advances after every data byte in both directions. The thermal flag latches and is cleared only by a status read made while the overtemperature input is low.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, CONTROL reads 0x20 (only the enable field set), the code for the first voltage register reads 0x3B and the second reads 0x41, and the field outputs reflect these values.
- R2: Only the 7-bit address 0x75 is acknowledged (address byte 0xEA for write, 0xEB for read). For any other address the target returns NACK and leaves SDA released. It ignores all following bytes until the next START.
- R3: A write of address+W, pointer 0x01 and a data byte loads CONTROL. Bit 6 drives range_o, bit 5 enable_o, bit 4 ooa_o, bit 3 fpwm_o, bit 2 rpwm_o and bits 1:0 slew_o. Bit 7 is stored as 0 and reads back as 0.
- R4: Registers 0x04 and 0x05 store a 7-bit code in bits 6:0, shown on vout1_o and vout2_o. Bit 7 is forced to 0 on write and reads as 0.
- R5: The register pointer increments after every data byte, both in a multi-byte write and in a multi-byte read.
- R6: A read is address+W, pointer, repeated START, address+R, then data bytes MSB first. Each byte the master acknowledges is followed by the next one. After the master's NACK the target keeps SDA released.
- R7: Register 0x03 reads 0x50. Writes to 0x02, 0x03 and unmapped pointers (0x00, 0x06 to 0xFF) are acknowledged and change nothing. Unmapped pointers read as 0x00.
- R8: STATUS (0x02) bit 0 reads the power-not-good input and bits 7:2 read 0.
- R9: STATUS bit 1 sets when the overtemperature input is high and stays set. A STATUS read returns 1 and clears the bit only if the overtemperature input is low at that read. A read while the input is high leaves the bit set.
- R10: The target changes its SDA drive and its register outputs only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, pull SDA low |
| ot_i | input | 1 | Overtemperature indication, synchronous |
| pgn_i | input | 1 | Power-not-good indication, synchronous |
| range_o | output | 1 | Voltage range select field |
| enable_o | output | 1 | Converter enable field |
| ooa_o | output | 1 | Out-of-audio field |
| fpwm_o | output | 1 | Forced-PWM field |
| rpwm_o | output | 1 | Ramp-PWM field |
| slew_o | output | 2 | Ramp slew-rate select |
| vout1_o | output | 7 | Voltage code of register 0x04 |
| vout2_o | output | 7 | Voltage code of register 0x05 |

## Verification
The hardest case to reach is a thermal flag read in the same status access that clears it. The byte must still show the flag while the flag drops behind it. A second case is the same read made while the overtemperature input is still high, which must not clear the flag. The stimulus pulses the input, performs back-to-back status reads, and repeats the sequence with the input held high across two reads before releasing it. Address mismatch is reached by sending a foreign address followed by what would be a valid register write. The stimulus then checks that the output codes did not move.

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] DEV_ADDR = 7'h75
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       ot_i,
  input  logic       pgn_i,
  output logic       range_o,
  output logic       enable_o,
  output logic       ooa_o,
  output logic       fpwm_o,
  output logic       rpwm_o,
  output logic [1:0] slew_o,
  output logic [6:0] vout1_o,
  output logic [6:0] vout2_o
);
  typedef enum logic [2:0] {IDLE, ADDR, PTR, WDAT, ACK, TX, RACK, HOLD} st_t;

  logic [2:0] scl_r, sda_r;
  st_t        st, after;
  logic [3:0] cnt;
  logic [7:0] sr, tx, ptr, rdata;
  logic [6:0] ctl, v1, v2;
  logic       tsd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
    end

  wire sda_s    = sda_r[1];
  wire scl_rise = scl_r[1] & ~scl_r[2];
  wire scl_fall = ~scl_r[1] & scl_r[2];
  wire scl_hi   = scl_r[1] & scl_r[2];
  wire start_c  = scl_hi & ~sda_r[1] & sda_r[2];
  wire stop_c   = scl_hi & sda_r[1] & ~sda_r[2];
  wire load     = scl_fall && ((st == ACK && after == TX) || st == RACK);
  wire quiet    = (st == IDLE) || (st == HOLD);

  always_comb
    case (ptr)
      8'h01:   rdata = {1'b0, ctl};
      8'h02:   rdata = {6'd0, tsd, pgn_i};
      8'h03:   rdata = 8'h50;
      8'h04:   rdata = {1'b0, v1};
      8'h05:   rdata = {1'b0, v2};
      default: rdata = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     tsd <= 1'b0;
    else if (ot_i)                  tsd <= 1'b1;
    else if (load && ptr == 8'h02)  tsd <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE;  after <= IDLE;
      cnt <= '0;   sr <= '0;  tx <= '0;  ptr <= '0;
      sda_oe <= 1'b0;
      ctl <= 7'h20;  v1 <= 7'h3B;  v2 <= 7'h41;
    end else if (start_c) begin
      st <= ADDR;  cnt <= '0;  sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= IDLE;  sda_oe <= 1'b0;
    end else begin
      case (st)
        ADDR, PTR, WDAT:
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == ADDR) begin
              if (sr[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;  st <= ACK;
                after  <= sr[0] ? TX : PTR;
              end else st <= HOLD;
            end else begin
              sda_oe <= 1'b1;  st <= ACK;  after <= WDAT;
              if (st == PTR) ptr <= sr;
              else begin
                case (ptr)
                  8'h01:   ctl <= sr[6:0];
                  8'h04:   v1  <= sr[6:0];
                  8'h05:   v2  <= sr[6:0];
                  default: ;
                endcase
                ptr <= ptr + 8'd1;
              end
            end
          end
        ACK:
          if (scl_fall && after != TX) begin
            sda_oe <= 1'b0;  st <= after;  cnt <= '0;
          end
        TX:
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;  st <= RACK;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
        RACK:
          if (scl_rise && sda_s) st <= HOLD;
        default: ;
      endcase
      if (load) begin
        tx <= rdata;  sda_oe <= ~rdata[7];
        ptr <= ptr + 8'd1;  cnt <= '0;  st <= TX;
      end
    end

  assign range_o  = ctl[6];
  assign enable_o = ctl[5];
  assign ooa_o    = ctl[4];
  assign fpwm_o   = ctl[3];
  assign rpwm_o   = ctl[2];
  assign slew_o   = ctl[1:0];
  assign vout1_o  = v1;
  assign vout2_o  = v2;
endmodule

module i2c_regfile_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       ot_i,
  input logic       tsd,
  input logic       quiet,
  input logic [6:0] v1,
  input logic [6:0] v2
);
  // R10
  sda_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);
  // R10
  vout_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(v1) || !$stable(v2)) |-> !scl_i);
  // R9
  tsd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |=> tsd);
  // R9
  tsd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd && ot_i) |=> tsd);
  // R2
  quiet_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !sda_oe);
endmodule

bind i2c_regfile_target i2c_regfile_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .ot_i(ot_i),
  .tsd(tsd), .quiet(quiet), .v1(vout1_o), .v2(vout2_o)
);

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, m_oe = 1'b0, ot = 1'b0, pgn = 1'b0;
  logic dut_oe, range_o, enable_o, ooa_o, fpwm_o, rpwm_o;
  logic [1:0] slew_o;
  logic [6:0] vout1_o, vout2_o;
  logic sda;
  assign sda = !(m_oe || dut_oe);

  i2c_regfile_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(dut_oe),
    .ot_i(ot), .pgn_i(pgn), .range_o(range_o), .enable_o(enable_o),
    .ooa_o(ooa_o), .fpwm_o(fpwm_o), .rpwm_o(rpwm_o), .slew_o(slew_o),
    .vout1_o(vout1_o), .vout2_o(vout2_o)
  );

  int total = 0, fails = 0, hp = 6;
  logic done = 1'b0;
  logic [7:0] rb [0:7];
  logic acks, released;
  wire [6:0] ctl_v = {range_o, enable_o, ooa_o, fpwm_o, rpwm_o, slew_o};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_oe = 1'b0; tick(hp); scl = 1'b1; tick(hp);
    m_oe = 1'b1; tick(hp); scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_oe = 1'b1; tick(hp); scl = 1'b1; tick(hp); m_oe = 1'b0; tick(hp);
  endtask

  task automatic byte_w(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_oe = !b[i]; tick(hp); scl = 1'b1; tick(hp); scl = 1'b0;
    end
    m_oe = 1'b0; tick(hp); scl = 1'b1; tick(hp); ack = !sda; scl = 1'b0;
  endtask

  task automatic byte_r(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_oe = 1'b0; tick(hp); scl = 1'b1; tick(hp); b[i] = sda; scl = 1'b0;
    end
    m_oe = give_ack; tick(hp); scl = 1'b1; tick(hp); scl = 1'b0;
  endtask

  task automatic wr_regs(input logic [7:0] p, input logic [7:0] d0,
                         input logic [7:0] d1, input int n);
    logic a;
    acks = 1'b1;
    bus_start();
    byte_w(8'hEA, a); acks &= a;
    byte_w(p, a);     acks &= a;
    byte_w(d0, a);    acks &= a;
    if (n > 1) begin byte_w(d1, a); acks &= a; end
    bus_stop();
  endtask

  task automatic rd_regs(input logic [7:0] p, input int n);
    logic a;
    logic [7:0] b;
    acks = 1'b1;
    bus_start();
    byte_w(8'hEA, a); acks &= a;
    byte_w(p, a);     acks &= a;
    bus_start();
    byte_w(8'hEB, a); acks &= a;
    for (int k = 0; k < n; k++) begin
      byte_r(k != n - 1, b);
      rb[k] = b;
    end
    m_oe = 1'b0; tick(hp); released = sda;
    bus_stop();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    logic a;
    logic [7:0] d, cexp;
    logic [6:0] ve1, ve2;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 reset state at the outputs and through reads
    chk("R1 control fields", ctl_v, 7'h20);
    chk("R1 vout1", vout1_o, 7'h3B);
    chk("R1 vout2", vout2_o, 7'h41);
    rd_regs(8'h01, 5);
    chk("R1 control read", rb[0], 8'h20);
    chk("R8 status read", rb[1], 8'h00);
    chk("R7 devid read", rb[2], 8'h50);
    chk("R1 vout1 read", rb[3], 8'h3B);
    chk("R5 burst read vout2", rb[4], 8'h41);
    chk("R6 acks on read", acks, 1'b1);
    chk("R6 released after nack", released, 1'b1);

    // R2 foreign address
    bus_start();
    byte_w(8'hE8, a);
    chk("R2 foreign address nack", a, 1'b0);
    byte_w(8'h04, a);
    chk("R2 ignored byte nack", a, 1'b0);
    byte_w(8'h11, a);
    bus_stop();
    chk("R2 vout1 untouched", vout1_o, 7'h3B);

    // R3 control sweep
    cexp = 8'h20;
    for (int i = 0; i < 64; i++) begin
      d = 8'((i * 37 + 5) & 8'hFF);
      wr_regs(8'h01, d, 8'h00, 1);
      cexp = {1'b0, d[6:0]};
      chk("R2 write acks", acks, 1'b1);
      chk("R3 control fields", ctl_v, d[6:0]);
      if (i % 8 == 0) begin
        rd_regs(8'h01, 1);
        chk("R3 control readback bit7 zero", rb[0], cexp);
      end
    end

    // R4 R5 voltage code sweep with burst writes, bit 7 always set
    ve1 = 7'h3B; ve2 = 7'h41;
    for (int v = 0; v < 128; v++) begin
      ve1 = 7'(v); ve2 = 7'(127 - v);
      wr_regs(8'h04, {1'b1, ve1}, {1'b1, ve2}, 2);
      chk("R4 vout1 code", vout1_o, ve1);
      chk("R5 burst write vout2 code", vout2_o, ve2);
      if (v % 16 == 0) begin
        rd_regs(8'h04, 2);
        chk("R4 vout1 readback", rb[0], {1'b0, ve1});
        chk("R4 vout2 readback", rb[1], {1'b0, ve2});
      end
    end

    // R7 read-only and unmapped
    wr_regs(8'h02, 8'hFF, 8'hFF, 2);
    chk("R7 write to read-only acked", acks, 1'b1);
    wr_regs(8'h07, 8'hAA, 8'h00, 1);
    wr_regs(8'h00, 8'hFF, 8'h00, 1);
    chk("R7 write to unmapped acked", acks, 1'b1);
    rd_regs(8'h00, 8);
    chk("R7 unmapped 0x00", rb[0], 8'h00);
    chk("R7 control kept", rb[1], cexp);
    chk("R7 status unwritten", rb[2], 8'h00);
    chk("R7 devid unwritten", rb[3], 8'h50);
    chk("R5 vout1 in long burst", rb[4], {1'b0, ve1});
    chk("R5 vout2 in long burst", rb[5], {1'b0, ve2});
    chk("R7 unmapped 0x06", rb[6], 8'h00);
    chk("R7 unmapped 0x07", rb[7], 8'h00);
    chk("R7 outputs kept", ctl_v, cexp[6:0]);

    // R8 power-not-good
    pgn = 1'b1; tick(2);
    rd_regs(8'h02, 1);
    chk("R8 status pgn high", rb[0], 8'h01);
    pgn = 1'b0; tick(2);
    rd_regs(8'h02, 1);
    chk("R8 status pgn low", rb[0], 8'h00);

    // R9 sticky thermal flag
    ot = 1'b1; tick(3); ot = 1'b0; tick(3);
    rd_regs(8'h02, 1);
    chk("R9 flag after pulse", rb[0], 8'h02);
    rd_regs(8'h02, 1);
    chk("R9 cleared by read", rb[0], 8'h00);
    ot = 1'b1; tick(3);
    rd_regs(8'h02, 1);
    chk("R9 flag while hot", rb[0], 8'h02);
    rd_regs(8'h02, 1);
    chk("R9 read while hot keeps flag", rb[0], 8'h02);
    ot = 1'b0; tick(3);
    rd_regs(8'h02, 1);
    chk("R9 flag kept after cooling", rb[0], 8'h02);
    rd_regs(8'h02, 1);
    chk("R9 cleared after cool read", rb[0], 8'h00);

    // R6 target still responsive after a nack-terminated read
    wr_regs(8'h05, 8'h15, 8'h00, 1);
    chk("R6 write after read", vout2_o, 7'h15);
    chk("R6 bus idle high", sda, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule